// File: doc/BRIEF.md
# Spread-Spectrum Dither and Output Prescaler Controller

This block sits next to a digitally tuned oscillator and runs on that oscillator's master clock. It has two jobs. It spreads the oscillator's spectrum by taking the programmed 10-bit tuning code and pulling it down by a triangle wave. The triangle's period and peak depth are both programmable. It also produces the block's output clock by dividing the master clock by a programmable power of two. When the output is disabled, that clock is either held low or released to high impedance.

One DAC step moves the master frequency by 5 kHz. The frequency range the tuning code works within is chosen by an offset setting outside this block. The dithered code therefore sweeps the master frequency down from its programmed value, by at most the chosen depth times 5 kHz. The triangle settings are captured only at the boundary of a modulation period. The divider setting is captured only at the boundary of a divider period. Because of this, setting changes produce no partial periods or glitches.

Top module: `ssd_dither_ctrl`

## Requirements
- R1: After synchronous reset the modulation period is 4096 master clocks, the depth is 0 (the dithered code equals the tuning code), the divider ratio is 1 and the period counters start at zero.
- R2: The rate code sets the triangle period in master clocks: 00 gives 8192, 01 gives 4096, and both 10 and 11 give 2048.
- R3: The depth code sets the peak triangle value in codes: 000 gives 0 (dithering off), 001 gives 4, 010 gives 8, 011 gives 16, 100 gives 32, and both 101 and any larger code give 64.
- R4: In a period of N clocks with peak D > 0, the triangle value is floor(n / (N/(2D))) for cycle n of the period while that quotient is at most D, and 2D minus the quotient after that. It rises one code per step to D and falls back to 1 before the period restarts.
- R5: The dithered code equals the tuning code minus the triangle value, or 0 when the triangle value is larger. It never exceeds the tuning code.
- R6: Rate and depth codes are captured only when the current modulation period ends. A change in the middle of a period has no effect on that period.
- R7: The prescaler code x gives an output period of 2^x master clocks with a 50 % duty cycle. The high half comes second in each period. Codes above 8 act as 8. Code 0 passes the master clock through.
- R8: A prescaler code change is captured only when the current divider period ends.
- R9: With the output enable at 1, the output clock toggles and its enable is 1. With the output enable at 0, the clock is 0. Its enable is then 0 if the park-high-impedance input is 1, and 1 (driven low) if that input is 0.
- R10: The triangle value never exceeds the captured depth. It changes by at most one code per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| dac_code | input | 10 | Programmed tuning code, 0 to 1023 |
| rate_code | input | 2 | Modulation rate selection |
| depth_code | input | 3 | Peak dither depth selection |
| presc_code | input | 4 | Output divider exponent |
| park_hiz | input | 1 | 1: disabled output goes high impedance; 0: driven low |
| out_en | input | 1 | Output clock enable |
| dith_code | output | 10 | Dithered tuning code |
| clk_div | output | 1 | Divided output clock |
| clk_div_oe | output | 1 | Output-driver enable for clk_div |

## Verification
Every cycle, the assertions check that the triangle stays within its captured peak and moves by at most one code. They also check that the captured rate, depth and divider settings stay fixed except at their period boundaries, and that the dithered code never exceeds the tuning code. Only the bench's scenarios can show the exact triangle shape for each rate and depth code, the clamp at zero, and the duty cycle and saturation of the divider. The same holds for the delayed capture of mid-period changes and the three output-disable cases. The bench compares all of these on every clock against an arithmetic model.

// File: rtl/ssd_pkg.sv
package ssd_pkg;

    localparam int DAC_W        = 10;
    localparam int DIV_MIN_LOG2 = 11;
    localparam int RATE_SPAN    = 2;
    localparam int PCNT_W       = DIV_MIN_LOG2 + RATE_SPAN;
    localparam int DEPTH_K_MAX  = 5;
    localparam int TRI_W        = DEPTH_K_MAX + 2;
    localparam int PRESC_MAX    = 8;
    localparam int XSEL_W       = 4;

    typedef enum logic [1:0] {
        RATE_SLOW = 2'b00,
        RATE_MID  = 2'b01,
        RATE_FAST = 2'b10,
        RATE_ALT  = 2'b11
    } rate_code_e;

    typedef struct packed {
        logic [3:0] rlog2;
        logic [2:0] dk;
    } dith_cfg_t;

    function automatic logic [3:0] rate_log2(input logic [1:0] code);
        int unsigned s;
        s = (code >= 2'd2) ? RATE_SPAN : int'(code);
        return 4'(DIV_MIN_LOG2 + RATE_SPAN - s);
    endfunction

    function automatic logic [2:0] depth_k(input logic [2:0] code);
        return (code > 3'(DEPTH_K_MAX)) ? 3'(DEPTH_K_MAX) : code;
    endfunction

    function automatic logic [XSEL_W-1:0] presc_sat(input logic [XSEL_W-1:0] code);
        return (code > XSEL_W'(PRESC_MAX)) ? XSEL_W'(PRESC_MAX) : code;
    endfunction

    function automatic logic [DAC_W-1:0] sat_sub(input logic [DAC_W-1:0] a,
                                                 input logic [TRI_W-1:0] b);
        logic [DAC_W:0] d;
        d = {1'b0, a} - (DAC_W+1)'(b);
        return d[DAC_W] ? '0 : d[DAC_W-1:0];
    endfunction

endpackage

// File: rtl/ssd_tri_gen.sv
module ssd_tri_gen
    import ssd_pkg::*;
#(
    parameter int P_PCNT_W = PCNT_W,
    parameter int P_TRI_W  = TRI_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         rate_code,
    input  logic [2:0]         depth_code,
    output logic [P_TRI_W-1:0] tri_val,
    output logic [P_TRI_W-1:0] depth_val
);

    dith_cfg_t           cfg_q;
    logic [P_PCNT_W-1:0] pcnt_q;
    logic [P_PCNT_W-1:0] last_cnt;
    logic                period_last;
    logic [P_PCNT_W-1:0] phase;
    logic [P_PCNT_W-1:0] two_d;
    logic [P_PCNT_W-1:0] peak;
    logic [3:0]          shamt;

    always_comb begin
        last_cnt    = P_PCNT_W'((33'd1 << cfg_q.rlog2) - 33'd1);
        period_last = (pcnt_q == last_cnt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pcnt_q      <= '0;
            cfg_q.rlog2 <= rate_log2(RATE_MID);
            cfg_q.dk    <= '0;
        end else if (period_last) begin
            pcnt_q      <= '0;
            cfg_q.rlog2 <= rate_log2(rate_code);
            cfg_q.dk    <= depth_k(depth_code);
        end else begin
            pcnt_q <= pcnt_q + 1'b1;
        end
    end

    // phase index = pcnt / (period / 2D), all powers of two
    always_comb begin
        two_d = P_PCNT_W'(1) << (cfg_q.dk + 3'd2);
        peak  = P_PCNT_W'(1) << (cfg_q.dk + 3'd1);
        shamt = cfg_q.rlog2 - 4'(cfg_q.dk) - 4'd2;
        phase = pcnt_q >> shamt;
        if (cfg_q.dk == '0) begin
            tri_val   = '0;
            depth_val = '0;
        end else begin
            depth_val = P_TRI_W'(peak);
            tri_val   = (phase <= peak) ? P_TRI_W'(phase) : P_TRI_W'(two_d - phase);
        end
    end

    p_tri_bound_r10: assert property (@(posedge clk) disable iff (rst)
        tri_val <= depth_val);

    p_tri_step_r10: assert property (@(posedge clk) disable iff (rst)
        ##1 ((tri_val == $past(tri_val)) ||
             ((P_TRI_W+1)'(tri_val) == (P_TRI_W+1)'($past(tri_val)) + 1'b1) ||
             ((P_TRI_W+1)'(tri_val) + 1'b1 == (P_TRI_W+1)'($past(tri_val)))));

    p_cfg_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !period_last |=> $stable(cfg_q));

endmodule

// File: rtl/ssd_prescaler.sv
module ssd_prescaler
    import ssd_pkg::*;
#(
    parameter int P_MAX    = PRESC_MAX,
    parameter int P_XSEL_W = XSEL_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [P_XSEL_W-1:0] presc_code,
    output logic                div_raw
);

    localparam int CNT_W = P_MAX;

    logic [P_XSEL_W-1:0] x_q;
    logic [CNT_W-1:0]    cnt_q;
    logic [CNT_W-1:0]    mask;
    logic                div_wrap;
    logic [CNT_W-1:0]    shifted;

    always_comb begin
        mask     = CNT_W'(((CNT_W+1)'(1) << x_q) - 1'b1);
        div_wrap = ((cnt_q & mask) == mask);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            x_q   <= '0;
            cnt_q <= '0;
        end else if (div_wrap) begin
            x_q   <= presc_sat(presc_code);
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // ratio 1 passes the master clock; otherwise the top counter bit of the period
    always_comb begin
        shifted = cnt_q >> (x_q - 1'b1);
        div_raw = (x_q == '0) ? clk : shifted[0];
    end

    p_div_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !div_wrap |=> $stable(x_q));

    p_div_range_r7: assert property (@(posedge clk) disable iff (rst)
        x_q <= P_XSEL_W'(P_MAX));

endmodule

// File: rtl/ssd_out_ctrl.sv
module ssd_out_ctrl (
    input  logic div_raw,
    input  logic out_en,
    input  logic park_hiz,
    output logic clk_out,
    output logic clk_oe
);

    always_comb begin
        clk_out = out_en & div_raw;
        clk_oe  = out_en | ~park_hiz;
    end

endmodule

// File: rtl/ssd_dither_ctrl.sv
module ssd_dither_ctrl
    import ssd_pkg::*;
#(
    parameter int P_DAC_W  = DAC_W,
    parameter int P_TRI_W  = TRI_W,
    parameter int P_XSEL_W = XSEL_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [P_DAC_W-1:0]  dac_code,
    input  logic [1:0]          rate_code,
    input  logic [2:0]          depth_code,
    input  logic [P_XSEL_W-1:0] presc_code,
    input  logic                park_hiz,
    input  logic                out_en,
    output logic [P_DAC_W-1:0]  dith_code,
    output logic                clk_div,
    output logic                clk_div_oe
);

    logic [P_TRI_W-1:0] tri_val;
    logic [P_TRI_W-1:0] depth_val;
    logic               div_raw;

    ssd_tri_gen #(.P_PCNT_W(PCNT_W), .P_TRI_W(P_TRI_W)) tri_i (
        .clk        (clk),
        .rst        (rst),
        .rate_code  (rate_code),
        .depth_code (depth_code),
        .tri_val    (tri_val),
        .depth_val  (depth_val)
    );

    ssd_prescaler #(.P_MAX(PRESC_MAX), .P_XSEL_W(P_XSEL_W)) presc_i (
        .clk        (clk),
        .rst        (rst),
        .presc_code (presc_code),
        .div_raw    (div_raw)
    );

    ssd_out_ctrl out_i (
        .div_raw  (div_raw),
        .out_en   (out_en),
        .park_hiz (park_hiz),
        .clk_out  (clk_div),
        .clk_oe   (clk_div_oe)
    );

    always_comb dith_code = sat_sub(dac_code, tri_val);

    p_dith_floor_r5: assert property (@(posedge clk) disable iff (rst)
        dith_code <= dac_code);

endmodule

// File: tb/ssd_dither_ctrl_tb.sv
`timescale 1ns/100ps
module ssd_dither_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] dac_code = 10'd500;
    logic [1:0] rate_code = 2'b01;
    logic [2:0] depth_code = 3'b000;
    logic [3:0] presc_code = 4'd0;
    logic       park_hiz = 1'b0;
    logic       out_en = 1'b1;
    logic [9:0] dith_code;
    logic       clk_div;
    logic       clk_div_oe;

    int n_chk = 0;
    int n_bad = 0;
    bit run_chk = 1'b0;
    string tag = "R1";

    always #2 clk = ~clk;

    ssd_dither_ctrl dut_i (
        .clk(clk), .rst(rst), .dac_code(dac_code), .rate_code(rate_code),
        .depth_code(depth_code), .presc_code(presc_code), .park_hiz(park_hiz),
        .out_en(out_en), .dith_code(dith_code), .clk_div(clk_div),
        .clk_div_oe(clk_div_oe)
    );

    // arithmetic reference model
    int m_pcnt, m_period, m_depth;
    int m_cnt, m_x;

    function automatic int period_of(input int rc);
        return (rc == 0) ? 8192 : (rc == 1) ? 4096 : 2048;
    endfunction

    function automatic int depth_of(input int dc);
        case (dc)
            0: return 0;
            1: return 4;
            2: return 8;
            3: return 16;
            4: return 32;
            default: return 64;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_pcnt <= 0; m_period <= 4096; m_depth <= 0;
            m_cnt <= 0; m_x <= 0;
        end else begin
            if (m_pcnt == m_period - 1) begin
                m_pcnt   <= 0;
                m_period <= period_of(int'(rate_code));
                m_depth  <= depth_of(int'(depth_code));
            end else m_pcnt <= m_pcnt + 1;
            if (m_cnt % (1 << m_x) == (1 << m_x) - 1) begin
                m_cnt <= 0;
                m_x   <= (presc_code > 4'd8) ? 8 : int'(presc_code);
            end else m_cnt <= m_cnt + 1;
        end
    end

    function automatic int exp_tri();
        int l, ph;
        if (m_depth == 0) return 0;
        l  = m_period / (2 * m_depth);
        ph = m_pcnt / l;
        return (ph <= m_depth) ? ph : 2 * m_depth - ph;
    endfunction

    function automatic int exp_dith();
        int t;
        t = exp_tri();
        return (int'(dac_code) >= t) ? int'(dac_code) - t : 0;
    endfunction

    function automatic int exp_clk();
        int raw;
        raw = (m_x == 0) ? int'(clk) : ((m_cnt >= (1 << (m_x - 1))) ? 1 : 0);
        return out_en ? raw : 0;
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        #0.5;
        if (run_chk && !rst) begin
            check(tag, "dith_code", int'(dith_code), exp_dith());
            check(tag, "clk_div", int'(clk_div), exp_clk());
            check(tag, "clk_div_oe", int'(clk_div_oe), (out_en || !park_hiz) ? 1 : 0);
        end
    end

    task automatic drive_wait(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wait_period_start();
        @(negedge clk);
        while (m_pcnt != 0) @(negedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        drive_wait(5);
        rst = 1'b0;
        // R1: reset state seen at the ports
        @(negedge clk); #0.5;
        check("R1", "dith after reset", int'(dith_code), 500);
        check("R1", "clk_div after reset", int'(clk_div), 0);
        check("R1", "oe after reset", int'(clk_div_oe), 1);
        #0.5;
        run_chk = 1'b1;
        tag = "R1";
        // R3: sweep every depth code at the fast rate
        dac_code = 10'd600; rate_code = 2'b10;
        for (int d = 0; d < 8; d++) begin
            depth_code = 3'(d);
            tag = "R3 R4";
            wait_period_start();
        end
        // R2: every rate code at the largest depth
        depth_code = 3'd5;
        for (int r = 0; r < 4; r++) begin
            rate_code = 2'(r);
            tag = "R2 R4";
            wait_period_start();
        end
        wait_period_start();
        // R5: clamp at zero with small tuning codes
        tag = "R5";
        rate_code = 2'b10; depth_code = 3'd5; dac_code = 10'd20;
        wait_period_start();
        wait_period_start();
        dac_code = 10'd0;
        drive_wait(1000);
        dac_code = 10'd1023;
        wait_period_start();
        // R6: mid-period change must wait for the boundary
        tag = "R6";
        drive_wait(100);
        rate_code = 2'b00; depth_code = 3'd2;
        wait_period_start();
        drive_wait(300);
        check("R6", "period captured", m_period, 8192);
        rate_code = 2'b10; depth_code = 3'd4;
        wait_period_start();
        // R7: every prescaler code, including saturating ones
        tag = "R7";
        for (int x = 0; x < 16; x++) begin
            presc_code = 4'(x);
            drive_wait(600);
        end
        presc_code = 4'd0;
        drive_wait(300);
        @(posedge clk); #1;
        check("R7", "ratio 1 follows clock high", int'(clk_div), 1);
        // R8: change in the middle of a divider period
        tag = "R8";
        presc_code = 4'd5;
        drive_wait(45);
        presc_code = 4'd2;
        drive_wait(40);
        presc_code = 4'd7;
        drive_wait(300);
        // R9: output disable cases
        tag = "R9";
        presc_code = 4'd1;
        drive_wait(260);
        out_en = 1'b0; park_hiz = 1'b0;
        drive_wait(20);
        park_hiz = 1'b1;
        drive_wait(20);
        check("R9", "oe when parked hi-z", int'(clk_div_oe), 0);
        out_en = 1'b1;
        drive_wait(20);
        check("R9", "oe when enabled", int'(clk_div_oe), 1);
        finish_run();
    end

endmodule